// File: doc/BRIEF.md
# PLL Control Register Interlock

This block holds the two software-visible registers that steer a clock generator's phase-locked loop. The first is an 8-bit multiplier register with two 4-bit factors, called N and L here. The second is a control register with a PLL-on bit and a base-clock select bit. A CPU writes either register through a single-cycle strobe, and the block accepts every write with no back-pressure.

Control writes are not stored as written. Cross-field rules filter them so that the clock switch never receives an unsafe combination: the VCO is never requested while the PLL is off, and the PLL is never turned off under a running VCO selection. The block also decodes the multiplier register into the effective N and L values. Both registers read back combinationally through a one-bit read address.

Control register layout (address 0): bit 0 is PLL on, bit 1 is VCO select. Bits 7..2 ignore writes and read as 0. Multiplier register layout (address 1): bits 7..4 hold N and bits 3..0 hold L.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset the control register reads 0x00 and the multiplier register reads 0x11. pll_en and vco_sel_req are 0, and n_eff and l_eff are both 1.
- R2: A write with wr_sel_prog=1 stores the byte in the multiplier register at the clock edge. n_eff then follows bits 7..4 and l_eff follows bits 3..0, and the read value equals the byte written.
- R3: An N field of 0 reads back as 0, but n_eff presents it as 1.
- R4: While L is 0, pll_en is 0 even if the PLL-on bit is set, and any write that tries to set the select bit leaves it clear.
- R5: A control write that sets the select bit while the stored PLL-on bit is 0 leaves the select bit at 0.
- R6: A control write that clears PLL on while the select bit is 1 leaves PLL on at 1.
- R7: A control write that would change both PLL on and select in the same cycle keeps select at its old value. PLL on is updated under R6.
- R8: A multiplier write that stores L=0 while select is 1 clears select at the same clock edge.
- R9: Legal control writes take effect at the next rising edge: enable, then select, then deselect, then disable. pll_en and vco_sel_req follow the stored bits.
- R10: Control writes to bits 7..2 have no effect, and those bits read as 0.
- R11: rd_data follows rd_sel_prog combinationally (0 for control, 1 for multiplier) without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel_prog | input | 1 | Write address: 0 control, 1 multiplier |
| wr_data | input | 8 | Write data |
| rd_sel_prog | input | 1 | Read address: 0 control, 1 multiplier |
| rd_data | output | 8 | Read data |
| pll_en | output | 1 | PLL enable to the analog loop |
| vco_sel_req | output | 1 | Select request to the clock switch |
| n_eff | output | 4 | Decoded N factor |
| l_eff | output | 4 | Decoded L factor |

## Verification
Two functions can act in the same cycle. One is the select-versus-enable interlock. The other is the select clear forced by a zero L, which can arrive while select is set, and a later select attempt then meets both the interlock and the zero-L block. The bench drives these collisions as back-to-back writes: it selects the VCO, stores L=0, and then retries the select. After each edge it checks that the control readback, vco_sel_req and pll_en all show the crystal clock with the PLL-on bit kept. Joint on/select writes are driven from both the idle and the selected state to show which field wins.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  typedef enum logic {
    ADDR_CTL  = 1'b0,
    ADDR_PROG = 1'b1
  } reg_addr_e;

  localparam int CTL_ON_BIT  = 0;
  localparam int CTL_SEL_BIT = 1;

  typedef struct packed {
    logic sel;
    logic on;
  } ctl_state_t;
endpackage

// File: rtl/pll_prog_reg.sv
module pll_prog_reg #(
  parameter int NW = 4,
  parameter int LW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [NW+LW-1:0] wr_data,
  output logic [NW-1:0]    n_raw,
  output logic [LW-1:0]    l_raw,
  output logic [NW-1:0]    n_eff,
  output logic [LW-1:0]    l_eff,
  output logic             l_zero,
  output logic             l_zero_store
);
  localparam logic [NW-1:0] N_ONE = NW'(1);
  localparam logic [LW-1:0] L_ONE = LW'(1);

  logic [NW-1:0] n_q;
  logic [LW-1:0] l_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q <= N_ONE;
      l_q <= L_ONE;
    end else if (wr_stb) begin
      n_q <= wr_data[NW+LW-1:LW];
      l_q <= wr_data[LW-1:0];
    end
  end

  always_comb begin
    n_raw        = n_q;
    l_raw        = l_q;
    n_eff        = (n_q == '0) ? N_ONE : n_q;
    l_eff        = l_q;
    l_zero       = (l_q == '0);
    l_zero_store = wr_stb && (wr_data[LW-1:0] == '0);
  end

  AST_N_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    n_eff != '0); // R3
  AST_PROG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> {n_raw, l_raw} == $past(wr_data)); // R2
endmodule

// File: rtl/pll_ctl_interlock.sv
module pll_ctl_interlock
  import pll_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_on,
  input  logic wr_sel,
  input  logic l_zero,
  input  logic force_xtal,
  output logic on_q,
  output logic sel_q
);
  ctl_state_t st_q, st_nxt;
  logic on_chg, sel_chg, joint;

  always_comb begin
    on_chg  = (wr_on != st_q.on);
    sel_chg = (wr_sel != st_q.sel);
    joint   = on_chg && sel_chg;
    st_nxt.on = (st_q.sel && !wr_on) ? 1'b1 : wr_on;
    if (joint)       st_nxt.sel = st_q.sel;
    else if (wr_sel) st_nxt.sel = st_q.on && !l_zero;
    else             st_nxt.sel = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (force_xtal) begin
      st_q.sel <= 1'b0;
    end else if (wr_stb) begin
      st_q <= st_nxt;
    end
  end

  assign on_q  = st_q.on;
  assign sel_q = st_q.sel;

  AST_SEL_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> on_q); // R5
  AST_OFF_BLOCKS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !on_q) |=> !sel_q); // R5
  AST_SEL_HOLDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && sel_q && !wr_on) |=> on_q); // R6
  AST_NO_JOINT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_on != on_q) && (wr_sel != sel_q)) |=> (sel_q == $past(sel_q))); // R7
  AST_FORCE_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    force_xtal |=> !sel_q); // R8
endmodule

// File: rtl/pll_rd_mux.sv
module pll_rd_mux
  import pll_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          rd_sel_prog,
  input  logic          on_q,
  input  logic          sel_q,
  input  logic [DW-1:0] prog_q,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] ctl_word;

  for (genvar b = 0; b < DW; b++) begin : g_ctl_bits
    if (b == CTL_ON_BIT) begin : g_on
      assign ctl_word[b] = on_q;
    end else if (b == CTL_SEL_BIT) begin : g_sel
      assign ctl_word[b] = sel_q;
    end else begin : g_pad
      assign ctl_word[b] = 1'b0;
    end
  end

  assign rd_data = (rd_sel_prog == ADDR_PROG) ? prog_q : ctl_word;
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
  import pll_ctl_pkg::*;
#(
  parameter int NW = 4,
  parameter int LW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel_prog,
  input  logic [NW+LW-1:0] wr_data,
  input  logic             rd_sel_prog,
  output logic [NW+LW-1:0] rd_data,
  output logic             pll_en,
  output logic             vco_sel_req,
  output logic [NW-1:0]    n_eff,
  output logic [LW-1:0]    l_eff
);
  localparam int DW = NW + LW;

  logic          prog_stb, ctl_stb;
  logic [NW-1:0] n_raw;
  logic [LW-1:0] l_raw;
  logic          l_zero, l_zero_store;
  logic          on_q, sel_q;

  assign prog_stb = wr_en && (wr_sel_prog == ADDR_PROG);
  assign ctl_stb  = wr_en && (wr_sel_prog == ADDR_CTL);

  pll_prog_reg #(.NW(NW), .LW(LW)) u_prog (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb       (prog_stb),
    .wr_data      (wr_data),
    .n_raw        (n_raw),
    .l_raw        (l_raw),
    .n_eff        (n_eff),
    .l_eff        (l_eff),
    .l_zero       (l_zero),
    .l_zero_store (l_zero_store)
  );

  pll_ctl_interlock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (ctl_stb),
    .wr_on      (wr_data[CTL_ON_BIT]),
    .wr_sel     (wr_data[CTL_SEL_BIT]),
    .l_zero     (l_zero),
    .force_xtal (l_zero_store),
    .on_q       (on_q),
    .sel_q      (sel_q)
  );

  pll_rd_mux #(.DW(DW)) u_rd (
    .rd_sel_prog (rd_sel_prog),
    .on_q        (on_q),
    .sel_q       (sel_q),
    .prog_q      ({n_raw, l_raw}),
    .rd_data     (rd_data)
  );

  assign pll_en      = on_q && !l_zero;
  assign vco_sel_req = sel_q;

  AST_L_ZERO_NO_VCO: assert property (@(posedge clk) disable iff (!rst_n)
    (l_eff == '0) |-> !vco_sel_req); // R4
  AST_VCO_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    vco_sel_req |-> pll_en); // R9
endmodule

// File: tb/tb_pll_ctl_regs.sv
module tb_pll_ctl_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel_prog = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel_prog = 1'b0;
  logic [7:0] rd_data;
  logic       pll_en, vco_sel_req;
  logic [3:0] n_eff, l_eff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       ra;
    logic [7:0] rd;
    logic       en;
    logic       sel;
    logic [3:0] n;
    logic [3:0] l;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_prog(wr_sel_prog),
    .wr_data(wr_data), .rd_sel_prog(rd_sel_prog), .rd_data(rd_data),
    .pll_en(pll_en), .vco_sel_req(vco_sel_req), .n_eff(n_eff), .l_eff(l_eff)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] e_ctl, input logic [7:0] e_prog,
                      input logic e_en, input logic e_sel,
                      input logic [3:0] e_n, input logic [3:0] e_l, input string tag);
    exp_t a, b;
    a = '{1'b0, e_ctl,  e_en, e_sel, e_n, e_l, tag};
    b = '{1'b1, e_prog, e_en, e_sel, e_n, e_l, tag};
    sb.push_back(a);
    sb.push_back(b);
  endtask

  task automatic wr(input logic a, input logic [7:0] d,
                    input logic [7:0] e_ctl, input logic [7:0] e_prog,
                    input logic e_en, input logic e_sel,
                    input logic [3:0] e_n, input logic [3:0] e_l, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_sel_prog = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    push(e_ctl, e_prog, e_en, e_sel, e_n, e_l, tag);
  endtask

  // Monitor: drains the scoreboard after each edge, switching the read
  // address without a clock to observe both registers (R11).
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        rd_sel_prog = e.ra;
        #1;
        cmp(e.tag, e.ra ? "R11 rd prog" : "R11 rd ctl", rd_data, e.rd);
        if (!e.ra) begin
          cmp(e.tag, "pll_en", pll_en, e.en);
          cmp(e.tag, "vco_sel_req", vco_sel_req, e.sel);
          cmp(e.tag, "n_eff", n_eff, e.n);
          cmp(e.tag, "l_eff", l_eff, e.l);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push(8'h00, 8'h11, 0, 0, 4'd1, 4'd1, "R1 reset");
    @(negedge clk);
    wr(0, 8'h02, 8'h00, 8'h11, 0, 0, 1, 1, "R5 select while off");
    wr(0, 8'h03, 8'h01, 8'h11, 1, 0, 1, 1, "R7 joint from idle");
    wr(0, 8'h03, 8'h03, 8'h11, 1, 1, 1, 1, "R9 select vco");
    wr(0, 8'h02, 8'h03, 8'h11, 1, 1, 1, 1, "R6 disable under select");
    wr(0, 8'h00, 8'h03, 8'h11, 1, 1, 1, 1, "R7 joint from selected");
    wr(0, 8'h01, 8'h01, 8'h11, 1, 0, 1, 1, "R9 deselect");
    wr(0, 8'hFD, 8'h01, 8'h11, 1, 0, 1, 1, "R10 upper bits ignored");
    wr(1, 8'h0A, 8'h01, 8'h0A, 1, 0, 1, 4'hA, "R3 zero N");
    wr(1, 8'h35, 8'h01, 8'h35, 1, 0, 3, 5, "R2 prog store");
    wr(0, 8'h03, 8'h03, 8'h35, 1, 1, 3, 5, "R9 reselect");
    wr(1, 8'h70, 8'h01, 8'h70, 0, 0, 7, 0, "R8 zero L forces crystal");
    wr(0, 8'h03, 8'h01, 8'h70, 0, 0, 7, 0, "R4 select with zero L");
    wr(0, 8'h00, 8'h00, 8'h70, 0, 0, 7, 0, "R9 disable");
    wr(1, 8'h02, 8'h00, 8'h02, 0, 0, 1, 2, "R2 prog nonzero L");
    wr(0, 8'h01, 8'h01, 8'h02, 1, 0, 1, 2, "R9 enable");
    wr(0, 8'h00, 8'h00, 8'h02, 0, 0, 1, 2, "R9 disable again");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule